// File: doc/BRIEF.md
# Up-Counting Timer Core with Control Register

This block is a 16-bit up-counting timer. A counter advances once per clock while the run enable is set. It wraps to zero after reaching the active reload value, and it raises a one-cycle update event at the wrap. The run enable and the other mode fields live in a control word that is reached through a small memory-mapped register bus. The same bus holds the reload value, the counter and a software update trigger.

The reload value can be applied at once or held in a buffer until the next update event. A single-shot mode clears the run enable when the update event fires. Update events can be blocked entirely. The update flag output can be limited to counter wrap only. A debug-halt input freezes the counter when a separate debug-stop configuration input allows it. A free-running divider produces a sampling-clock enable for downstream input filters, and its rate is picked from the control word.

The bus is plain and always ready. A write happens in the cycle where `bus_wr_en` is high. Reads are combinational from `bus_addr` and have no side effects. There is no data stream and so no back-pressure.

Top module: `tmr_core`

## Requirements
- R1: After reset the control word reads 0x0000, the counter is 0, the active and buffered reload values are 0xFFFF, and `upd_evt_o` and `upd_flag_o` are low.
- R2: The control word (word select 0, byte address 0x0) keeps the divider select in bits 9:8, reload buffering in bit 7, single-shot in bit 6-free position bit 3, wrap-only flag in bit 2, update block in bit 1 and run enable in bit 0. Bits 15:10 and 6:4 always read as zero.
- R3: A write is accepted only when `bus_size` is 1 (16-bit) or 2 (32-bit) and `bus_addr[1:0]` is 00. Byte writes (`bus_size`=0) and misaligned writes change nothing. Reads return the register for any access size.
- R4: While the run enable is set, each clock adds one to the counter. When the counter equals the active reload value, the next clock sets it to 0, and `upd_evt_o` is high for the one cycle that follows that clock.
- R5: The reload register sits at byte address 0x4. With buffering off (bit 7 = 0), a write changes `reload_o` on the next clock. With buffering on, `reload_o` keeps its old value, and the buffered value (read back at 0x4) is copied to `reload_o` at the next unblocked update event.
- R6: With single-shot set (bit 3), the clock that raises an update event also clears the run enable, so the counter stays at 0 afterwards.
- R7: With update block set (bit 1), no update event is raised, no reload transfer happens and single-shot does not clear the run enable. The counter still wraps to 0.
- R8: Writing 1 in bit 0 at byte address 0xC is a software update. It clears the counter and raises an update event unless blocked. `upd_flag_o` follows every update event when bit 2 is 0. When bit 2 is 1, it follows only events caused by counter wrap.
- R9: While `dbg_halt_i` and `dbg_stop_cfg_i` are both high, the counter holds its value. If `dbg_halt_i` is high and `dbg_stop_cfg_i` is low, counting continues.
- R10: `smp_en_o` is high on every cycle for divider select 00 or 11. It is high on one cycle in 2 for select 01, and on one cycle in 4 for select 10.
- R11: A write at byte address 0x8 loads the counter on the next clock, and reads there return the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| dbg_halt_i | input | 1 | Debug halt indication |
| dbg_stop_cfg_i | input | 1 | Allows the debug halt to freeze the counter |
| cnt_o | output | 16 | Current counter value |
| reload_o | output | 16 | Active reload value |
| upd_evt_o | output | 1 | One-cycle update event pulse |
| upd_flag_o | output | 1 | Update flag pulse, filtered by the wrap-only field |
| smp_en_o | output | 1 | Sampling-clock enable for input filters |

## Verification
A register write takes effect on the clock edge where it is presented. The bench drives each write half a cycle before that edge and checks its effect at the following falling edge. The counter, active reload value and event outputs are all registered, so each counting step is checked one falling edge after the edge that produced it. An update event is therefore seen in the same sample where the counter first reads 0. Reads and `smp_en_o` are combinational and are sampled within the same half cycle. The bench keeps its own model of the counter and the enable state, and advances that model by one step per clock edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W = 16;

  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_RELOAD = 2'd1;
  localparam logic [1:0] SEL_COUNT  = 2'd2;
  localparam logic [1:0] SEL_EVENT  = 2'd3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    DIV_1    = 2'd0,
    DIV_2    = 2'd1,
    DIV_4    = 2'd2,
    DIV_RSVD = 2'd3
  } smp_div_e;

  typedef struct packed {
    smp_div_e smp_div;
    logic     reload_buf;
    logic     single_shot;
    logic     flag_ovf_only;
    logic     upd_block;
    logic     run_en;
  } ctrl_t;

  // Field positions are fixed by the software view of the control word.
  function automatic logic [BUS_W-1:0] ctrl_pack(ctrl_t c);
    return {6'b0, c.smp_div, c.reload_buf, 3'b0,
            c.single_shot, c.flag_ovf_only, c.upd_block, c.run_en};
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [BUS_W-1:0] w);
    ctrl_t c;
    c.smp_div       = smp_div_e'(w[9:8]);
    c.reload_buf    = w[7];
    c.single_shot   = w[3];
    c.flag_ovf_only = w[2];
    c.upd_block     = w[1];
    c.run_en        = w[0];
    return c;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_en,
  input  logic [3:0]       bus_addr,
  input  acc_size_e        bus_size,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             stop_req_i,
  input  logic [CNT_W-1:0] cnt_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] reload_pre_o,
  output logic             reload_wr_o,
  output logic             cnt_wr_o,
  output logic [CNT_W-1:0] wr_data_o,
  output logic             sw_upd_o
);
  logic       wr_ok;
  logic [1:0] sel;
  ctrl_t      ctrl_q;
  logic [CNT_W-1:0] pre_q;

  assign sel   = bus_addr[3:2];
  assign wr_ok = bus_wr_en && (bus_size == SZ_HALF || bus_size == SZ_WORD)
                 && (bus_addr[1:0] == 2'b00);

  assign wr_data_o   = bus_wdata[CNT_W-1:0];
  assign reload_wr_o = wr_ok && (sel == SEL_RELOAD);
  assign cnt_wr_o    = wr_ok && (sel == SEL_COUNT);
  assign sw_upd_o    = wr_ok && (sel == SEL_EVENT) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= RELOAD_RST;
    end else begin
      if (wr_ok && sel == SEL_CTRL) ctrl_q <= ctrl_unpack(bus_wdata);
      if (stop_req_i) ctrl_q.run_en <= 1'b0;
      if (reload_wr_o) pre_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:   bus_rdata = ctrl_pack(ctrl_q);
      SEL_RELOAD: bus_rdata = BUS_W'(pre_q);
      SEL_COUNT:  bus_rdata = BUS_W'(cnt_i);
      default:    bus_rdata = '0;
    endcase
  end

  assign ctrl_o       = ctrl_q;
  assign reload_pre_o = pre_q;

  // R6: a single-shot stop request leaves the run enable cleared
  p_opm_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req_i |=> !ctrl_q.run_en);

  // R3: byte-wide writes leave the control word untouched
  p_byte_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_size == SZ_BYTE && !stop_req_i) |=> $stable(ctrl_q));
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl_i,
  input  logic [CNT_W-1:0] reload_pre_i,
  input  logic             reload_wr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             sw_upd_i,
  input  logic             dbg_halt_i,
  input  logic             dbg_stop_cfg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             upd_evt_o,
  output logic             upd_flag_o,
  output logic             stop_req_o
);
  logic [CNT_W-1:0] cnt_q, reload_q;
  logic evt_q, flag_q;
  logic run, at_top, ovf, upd_now;

  assign run     = ctrl_i.run_en && !(dbg_halt_i && dbg_stop_cfg_i);
  assign at_top  = (cnt_q == reload_q);
  assign ovf     = run && at_top;
  assign upd_now = (ovf || sw_upd_i) && !ctrl_i.upd_block;
  assign stop_req_o = upd_now && ctrl_i.single_shot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= RELOAD_RST;
      evt_q    <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (sw_upd_i)      cnt_q <= '0;
      else if (cnt_wr_i) cnt_q <= wr_data_i;
      else if (run)      cnt_q <= at_top ? '0 : cnt_q + CNT_W'(1);

      if (reload_wr_i && !ctrl_i.reload_buf) reload_q <= wr_data_i;
      else if (upd_now)                      reload_q <= reload_pre_i;

      evt_q  <= upd_now;
      flag_q <= upd_now && (ovf || !ctrl_i.flag_ovf_only);
    end
  end

  assign cnt_o      = cnt_q;
  assign reload_o   = reload_q;
  assign upd_evt_o  = evt_q;
  assign upd_flag_o = flag_q;

  // R4: reaching the reload value wraps to zero
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !sw_upd_i && !cnt_wr_i) |=> cnt_q == '0);

  // R4: below the reload value the counter advances by one
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_top && !sw_upd_i && !cnt_wr_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R9: debug freeze holds the counter
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.run_en && dbg_halt_i && dbg_stop_cfg_i && !sw_upd_i && !cnt_wr_i)
      |=> $stable(cnt_q));

  // R7: blocked updates produce no event
  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_i.upd_block |=> !evt_q);

  // R8: the flag never appears without an event
  p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> evt_q);
endmodule

// File: rtl/tmr_smpdiv.sv
module tmr_smpdiv
  import tmr_pkg::*;
#(
  parameter int MAX_RATIO = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  smp_div_e smp_div_i,
  output logic     smp_en_o
);
  localparam int DW = $clog2(MAX_RATIO);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + DW'(1);
  end

  always_comb begin
    case (smp_div_i)
      DIV_2:   smp_en_o = div_q[0];
      DIV_4:   smp_en_o = &div_q[1:0];
      default: smp_en_o = 1'b1;
    endcase
  end

  // R10: divide-by-four enable never stays high two cycles running
  p_div4_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_div_i == DIV_4 && smp_en_o) |=> (smp_div_i != DIV_4) || !smp_en_o);

  // R10: divide-by-two enable alternates
  p_div2_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_div_i == DIV_2 && smp_en_o) |=> (smp_div_i != DIV_2) || !smp_en_o);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_en,
  input  logic [3:0]       bus_addr,
  input  logic [1:0]       bus_size,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  logic             dbg_halt_i,
  input  logic             dbg_stop_cfg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             upd_evt_o,
  output logic             upd_flag_o,
  output logic             smp_en_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload_pre, wr_data;
  logic             reload_wr, cnt_wr, sw_upd, stop_req;

  tmr_regs #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_en    (bus_wr_en),
    .bus_addr     (bus_addr),
    .bus_size     (acc_size_e'(bus_size)),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .stop_req_i   (stop_req),
    .cnt_i        (cnt_o),
    .ctrl_o       (ctrl),
    .reload_pre_o (reload_pre),
    .reload_wr_o  (reload_wr),
    .cnt_wr_o     (cnt_wr),
    .wr_data_o    (wr_data),
    .sw_upd_o     (sw_upd)
  );

  tmr_count #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_count (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrl_i         (ctrl),
    .reload_pre_i   (reload_pre),
    .reload_wr_i    (reload_wr),
    .cnt_wr_i       (cnt_wr),
    .wr_data_i      (wr_data),
    .sw_upd_i       (sw_upd),
    .dbg_halt_i     (dbg_halt_i),
    .dbg_stop_cfg_i (dbg_stop_cfg_i),
    .cnt_o          (cnt_o),
    .reload_o       (reload_o),
    .upd_evt_o      (upd_evt_o),
    .upd_flag_o     (upd_flag_o),
    .stop_req_o     (stop_req)
  );

  tmr_smpdiv #(.MAX_RATIO(4)) u_smpdiv (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_div_i (ctrl.smp_div),
    .smp_en_o  (smp_en_o)
  );
endmodule

// File: tb/tmr_core_test.sv
module tmr_core_test;
  localparam logic [3:0] A_CTRL = 4'h0, A_RELOAD = 4'h4, A_COUNT = 4'h8, A_EVENT = 4'hC;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd1;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        dbg_halt_i = 1'b0, dbg_stop_cfg_i = 1'b0;
  logic [15:0] cnt_o, reload_o;
  logic        upd_evt_o, upd_flag_o, smp_en_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  tmr_core uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_halt_i(dbg_halt_i), .dbg_stop_cfg_i(dbg_stop_cfg_i),
    .cnt_o(cnt_o), .reload_o(reload_o), .upd_evt_o(upd_evt_o),
    .upd_flag_o(upd_flag_o), .smp_en_o(smp_en_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [15:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic restart(input logic [15:0] rl, input logic [15:0] ctl);
    wr(A_CTRL, 2'd1, 16'h0000);
    wr(A_COUNT, 2'd1, 16'h0000);
    wr(A_RELOAD, 2'd1, rl);
    wr(A_CTRL, 2'd1, ctl);
  endtask

  task automatic sweep(input int rl, input bit ovf_only);
    restart(16'(rl), ovf_only ? 16'h0005 : 16'h0001);
    chk("R5 direct reload", int'(reload_o), rl);
    for (int k = 1; k <= 3 * (rl + 1) + 1; k++) begin
      @(negedge clk);
      chk("R4 count", int'(cnt_o), k % (rl + 1));
      chk("R4 event", int'(upd_evt_o), int'(k % (rl + 1) == 0));
      chk("R8 wrap flag", int'(upd_flag_o), int'(k % (rl + 1) == 0));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int pulses, exp_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_CTRL, d);
    chk("R1 ctrl", int'(d), 0);
    chk("R1 count", int'(cnt_o), 0);
    chk("R1 reload", int'(reload_o), 16'hFFFF);
    rd(A_RELOAD, d);
    chk("R1 buffered reload", int'(d), 16'hFFFF);
    chk("R1 event", int'(upd_evt_o), 0);
    chk("R1 flag", int'(upd_flag_o), 0);

    // R3 rejected writes
    wr(A_CTRL, 2'd0, 16'h0001);
    rd(A_CTRL, d);
    chk("R3 byte write ignored", int'(d), 0);
    wr(4'h2, 2'd1, 16'h0001);
    rd(A_CTRL, d);
    chk("R3 misaligned write ignored", int'(d), 0);
    @(negedge clk);
    chk("R3 counter idle", int'(cnt_o), 0);

    // R2 field layout, reserved bits
    wr(A_CTRL, 2'd2, 16'hFFFF);
    rd(A_CTRL, d);
    chk("R2 reserved zero", int'(d), 16'h038F);
    wr(A_CTRL, 2'd1, 16'h0000);
    rd(A_CTRL, d);
    chk("R2 cleared", int'(d), 0);

    // R11 counter load
    wr(A_COUNT, 2'd2, 16'h1234);
    chk("R11 counter load", int'(cnt_o), 16'h1234);
    rd(A_COUNT, d);
    chk("R11 counter read", int'(d), 16'h1234);

    // R4 sweeps over small reload values, R8 wrap flag with wrap-only set
    for (int r = 0; r <= 5; r++) sweep(r, 1'b0);
    sweep(3, 1'b1);

    // R6 single-shot
    restart(16'd3, 16'h0009);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R6 count", int'(cnt_o), (k <= 3) ? k : 0);
      chk("R6 event", int'(upd_evt_o), int'(k == 4));
    end
    rd(A_CTRL, d);
    chk("R6 run enable cleared", int'(d), 16'h0008);

    // R7 update block
    restart(16'd2, 16'h000B);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      chk("R7 count wraps", int'(cnt_o), k % 3);
      chk("R7 no event", int'(upd_evt_o), 0);
    end
    rd(A_CTRL, d);
    chk("R7 run enable kept", int'(d), 16'h000B);

    // R5 buffered reload, R8 software update
    wr(A_CTRL, 2'd1, 16'h0000);
    wr(A_RELOAD, 2'd1, 16'd4);
    chk("R5 direct write", int'(reload_o), 4);
    wr(A_CTRL, 2'd1, 16'h0080);
    wr(A_RELOAD, 2'd1, 16'd7);
    chk("R5 buffered held", int'(reload_o), 4);
    rd(A_RELOAD, d);
    chk("R5 buffered readback", int'(d), 7);
    wr(A_COUNT, 2'd1, 16'd2);
    wr(A_EVENT, 2'd1, 16'h0001);
    chk("R8 sw update clears", int'(cnt_o), 0);
    chk("R8 sw event", int'(upd_evt_o), 1);
    chk("R8 sw flag", int'(upd_flag_o), 1);
    chk("R5 transfer at update", int'(reload_o), 7);
    @(negedge clk);
    chk("R8 event one cycle", int'(upd_evt_o), 0);
    wr(A_CTRL, 2'd1, 16'h0084);
    wr(A_RELOAD, 2'd1, 16'd9);
    wr(A_EVENT, 2'd1, 16'h0001);
    chk("R8 sw event wrap-only", int'(upd_evt_o), 1);
    chk("R8 sw flag suppressed", int'(upd_flag_o), 0);
    chk("R5 transfer second", int'(reload_o), 9);
    wr(A_CTRL, 2'd1, 16'h0082);
    wr(A_RELOAD, 2'd1, 16'd11);
    wr(A_COUNT, 2'd1, 16'd5);
    wr(A_EVENT, 2'd1, 16'h0001);
    chk("R8 sw clear while blocked", int'(cnt_o), 0);
    chk("R7 blocked sw event", int'(upd_evt_o), 0);
    chk("R7 blocked transfer", int'(reload_o), 9);

    // R9 debug freeze
    restart(16'd20, 16'h0001);
    exp_cnt = 0;
    for (int i = 1; i <= 12; i++) begin
      dbg_halt_i     = (i >= 4 && i <= 9);
      dbg_stop_cfg_i = !(i == 8 || i == 9);
      if (!(dbg_halt_i && dbg_stop_cfg_i)) exp_cnt++;
      @(negedge clk);
      chk("R9 debug count", int'(cnt_o), exp_cnt);
    end
    dbg_halt_i = 1'b0;
    dbg_stop_cfg_i = 1'b0;

    // R10 sampling enable rates
    for (int c = 0; c < 4; c++) begin
      wr(A_CTRL, 2'd1, 16'(c << 8));
      pulses = 0;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        pulses += int'(smp_en_o);
      end
      chk("R10 sample rate", pulses, (c == 1) ? 8 : (c == 2) ? 4 : 16);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule